// File: doc/BRIEF.md
# Serial Management Slave with Indirect Extended Register Access

This block is the management-port end of a PHY. It sits on the two-wire management bus and runs entirely from the management clock. On each rising clock edge it samples the data line and decodes one bit of a clause 22 frame. It can read or write a bank of thirty-two 16-bit registers. The shared data line is split into three signals: an input, an output value and an output enable. The pad, the pull-up and the tristate buffer stay outside the block. The management clock may stop between frames, so the block does no work while the bus is idle.

The block takes its bus address from four strap inputs. It captures them on the first clock edge after reset, and it ignores the line on that same edge. Two of the thirty-two register locations form an indirect window into a small extended register space. Location 13 holds a function select and a device number. Location 14 returns either the extended address or the extended data word, depending on that function. Depending on the function, the extended address can advance after a data access.

Top module: `mdio_slave_top`

## Requirements
- R1: A frame is recognised only after at least one sampled 1 followed by the start pattern 0,1. Then come a 2-bit opcode, a 5-bit slave address, a 5-bit register address, 2 turnaround bits and 16 data bits, each field MSB first.
- R2: Opcode 10 is a read and opcode 01 is a write. Opcodes 00 and 11 abandon the frame, and the slave then waits for a new idle 1 and start pattern.
- R3: The slave responds only when the top bit of the frame's slave address is 0 and the low four bits equal the captured strap. A frame for any other address is followed to its end with the output enable low and no register change.
- R4: On a matching read, the output enable is low during the first turnaround bit and high for the second. During the second turnaround bit the slave drives 0. It then drives the 16 data bits MSB first and drops the enable after the last bit. The data are captured when the register address field ends.
- R5: On a write, the output enable stays low for the whole frame. The data word is committed to the addressed register only after the 16th data bit.
- R6: The strap inputs are captured on the first rising clock edge after reset release. Later strap changes have no effect.
- R7: The first rising clock edge after reset release does not sample the line, so a 1 on that edge does not count as idle.
- R8: Register addresses other than 13 and 14 are plain 16-bit read/write storage. All of them read 0 after reset.
- R9: Register 13 keeps bits [15:14] as the indirect function and bits [4:0] as a device number. Bits [13:5] read back as 0.
- R10: With function 00, register 14 reads and writes the full 16-bit extended address. The extended store has 16 words, selected by the low 4 address bits, and all of them read 0 after reset.
- R11: With function 01, register 14 reads and writes the extended word at the current address, and the address does not change.
- R12: With function 10, the extended address increments by one after every read or write of register 14.
- R13: With function 11, the extended address increments after a write of register 14 and stays unchanged after a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; the line is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_addr | input | 4 | Address strap, captured on the first edge after reset |
| mdio_in | input | 1 | Sampled level of the data line |
| mdio_out | output | 1 | Value driven onto the data line while enabled |
| mdio_oe | output | 1 | Output enable for the data-line driver |

## Verification
Some properties of the read turnaround are checked on every cycle: a new drive period always begins with a 0 and lasts exactly 17 bit times. Other cycle-by-cycle checks are that the driver is never enabled before the slave is armed, during a write frame, or for a frame that did not match. The strap value is also checked to stay fixed once the slave is armed. Only the bench scenarios can show that read data match earlier writes, that aborted opcodes and the ignored first edge leave no trace, and that the extended address increments as each indirect function requires.

// File: rtl/mdio_slave_pkg.sv
package mdio_slave_pkg;
  localparam int DW        = 16;
  localparam int RAW       = 5;
  localparam int NREG      = 1 << RAW;
  localparam int STRAP_W   = 4;
  localparam int EXT_AW    = 4;
  localparam int EXT_DEPTH = 1 << EXT_AW;
  localparam int CNT_W     = 5;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;

  localparam logic [RAW-1:0] IND_CTRL_ADDR = 5'd13;
  localparam logic [RAW-1:0] IND_DATA_ADDR = 5'd14;

  typedef enum logic [1:0] {
    FN_ADDR    = 2'b00,
    FN_DATA    = 2'b01,
    FN_INC_RW  = 2'b10,
    FN_INC_WR  = 2'b11
  } ind_fn_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_OP,
    ST_PHY,
    ST_REG,
    ST_TA,
    ST_DATA
  } frame_st_e;
endpackage

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_slave_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               line_in,
  input  logic [STRAP_W-1:0] strap,
  input  logic [DW-1:0]      rd_data,
  output logic [RAW-1:0]     rd_addr,
  output logic               rd_req,
  output logic [RAW-1:0]     wr_addr,
  output logic               wr_stb,
  output logic [DW-1:0]      wr_data,
  output logic               drv_val,
  output logic               drv_en,
  output logic               addr_match,
  output logic               frame_wr
);
  frame_st_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DW-1:0]    sh_q, sh_d;
  logic [DW-1:0]    tx_q, tx_d;
  logic [RAW-1:0]   ra_q, ra_d;
  logic             seen_q, seen_d;
  logic             match_q, match_d;
  logic             rd_q, rd_d;
  logic             wr_q, wr_d;
  logic             oe_q, oe_d;
  logic             out_q, out_d;
  logic [RAW-1:0]   field5;

  assign field5 = {sh_q[RAW-2:0], line_in};

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    sh_d    = {sh_q[DW-2:0], line_in};
    tx_d    = tx_q;
    ra_d    = ra_q;
    seen_d  = seen_q;
    match_d = match_q;
    rd_d    = rd_q;
    wr_d    = wr_q;
    oe_d    = oe_q;
    out_d   = out_q;
    rd_req  = 1'b0;
    wr_stb  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        match_d = 1'b0;
        rd_d    = 1'b0;
        wr_d    = 1'b0;
        if (line_in)     seen_d = 1'b1;
        else if (seen_q) st_d   = ST_START;
      end
      ST_START: begin
        if (line_in) begin
          st_d  = ST_OP;
          cnt_d = '0;
        end else begin
          st_d   = ST_IDLE;
          seen_d = 1'b0;
        end
      end
      ST_OP: begin
        if (cnt_q == '0) begin
          cnt_d = 5'd1;
        end else begin
          cnt_d = '0;
          if ({sh_q[0], line_in} == OP_READ) begin
            rd_d = 1'b1;
            st_d = ST_PHY;
          end else if ({sh_q[0], line_in} == OP_WRITE) begin
            wr_d = 1'b1;
            st_d = ST_PHY;
          end else begin
            st_d   = ST_IDLE;
            seen_d = 1'b0;
          end
        end
      end
      ST_PHY: begin
        cnt_d = cnt_q + 5'd1;
        if (cnt_q == 5'(RAW-1)) begin
          match_d = (field5 == {1'b0, strap});
          cnt_d   = '0;
          st_d    = ST_REG;
        end
      end
      ST_REG: begin
        cnt_d = cnt_q + 5'd1;
        if (cnt_q == 5'(RAW-1)) begin
          ra_d  = field5;
          cnt_d = '0;
          st_d  = ST_TA;
          if (rd_q && match_q) begin
            rd_req = 1'b1;
            tx_d   = rd_data;
          end
        end
      end
      ST_TA: begin
        if (cnt_q == '0) begin
          cnt_d = 5'd1;
          if (rd_q && match_q) begin
            oe_d  = 1'b1;
            out_d = 1'b0;
          end
        end else begin
          cnt_d = '0;
          st_d  = ST_DATA;
          out_d = tx_q[DW-1];
          tx_d  = {tx_q[DW-2:0], 1'b0};
        end
      end
      ST_DATA: begin
        cnt_d = cnt_q + 5'd1;
        out_d = tx_q[DW-1];
        tx_d  = {tx_q[DW-2:0], 1'b0};
        if (cnt_q == 5'(DW-1)) begin
          st_d   = ST_IDLE;
          seen_d = 1'b0;
          oe_d   = 1'b0;
          out_d  = 1'b0;
          cnt_d  = '0;
          if (wr_q && match_q) wr_stb = 1'b1;
        end
      end
      default: begin
        st_d   = ST_IDLE;
        seen_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      ra_q    <= '0;
      seen_q  <= 1'b0;
      match_q <= 1'b0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      oe_q    <= 1'b0;
      out_q   <= 1'b0;
    end else if (en) begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      ra_q    <= ra_d;
      seen_q  <= seen_d;
      match_q <= match_d;
      rd_q    <= rd_d;
      wr_q    <= wr_d;
      oe_q    <= oe_d;
      out_q   <= out_d;
    end
  end

  assign rd_addr    = field5;
  assign wr_addr    = ra_q;
  assign wr_data    = {sh_q[DW-2:0], line_in};
  assign drv_val    = out_q;
  assign drv_en     = oe_q;
  assign addr_match = match_q;
  assign frame_wr   = wr_q;
endmodule

// File: rtl/mdio_regbank.sv
module mdio_regbank
  import mdio_slave_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [RAW-1:0] rd_addr,
  input  logic           rd_req,
  output logic [DW-1:0]  rd_data,
  input  logic [RAW-1:0] wr_addr,
  input  logic           wr_stb,
  input  logic [DW-1:0]  wr_data
);
  logic [DW-1:0]     plain_q [NREG];
  ind_fn_e           fn_q, fn_d;
  logic [4:0]        dev_q, dev_d;
  logic [DW-1:0]     xaddr_q, xaddr_d;
  logic [DW-1:0]     ext_q [EXT_DEPTH];
  logic [EXT_AW-1:0] xidx;
  logic              ext_we;

  assign xidx = xaddr_q[EXT_AW-1:0];

  for (genvar g = 0; g < NREG; g++) begin : g_plain
    if (g == int'(IND_CTRL_ADDR) || g == int'(IND_DATA_ADDR)) begin : g_hole
      assign plain_q[g] = '0;
    end else begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                      plain_q[g] <= '0;
        else if (en && wr_stb && wr_addr == RAW'(g))     plain_q[g] <= wr_data;
      end
    end
  end

  always_comb begin
    unique case (rd_addr)
      IND_CTRL_ADDR: rd_data = {fn_q, 9'd0, dev_q};
      IND_DATA_ADDR: rd_data = (fn_q == FN_ADDR) ? xaddr_q : ext_q[xidx];
      default:       rd_data = plain_q[rd_addr];
    endcase
  end

  always_comb begin
    fn_d    = fn_q;
    dev_d   = dev_q;
    xaddr_d = xaddr_q;
    ext_we  = 1'b0;
    if (wr_stb && wr_addr == IND_CTRL_ADDR) begin
      fn_d  = ind_fn_e'(wr_data[DW-1:DW-2]);
      dev_d = wr_data[4:0];
    end else if (wr_stb && wr_addr == IND_DATA_ADDR) begin
      if (fn_q == FN_ADDR) begin
        xaddr_d = wr_data;
      end else begin
        ext_we = 1'b1;
        if (fn_q != FN_DATA) xaddr_d = xaddr_q + 16'd1;
      end
    end else if (rd_req && rd_addr == IND_DATA_ADDR && fn_q == FN_INC_RW) begin
      xaddr_d = xaddr_q + 16'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fn_q    <= FN_ADDR;
      dev_q   <= '0;
      xaddr_q <= '0;
    end else if (en) begin
      fn_q    <= fn_d;
      dev_q   <= dev_d;
      xaddr_q <= xaddr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < EXT_DEPTH; i++) ext_q[i] <= '0;
    end else if (en && ext_we) begin
      ext_q[xidx] <= wr_data;
    end
  end
endmodule

// File: rtl/mdio_slave_top.sv
module mdio_slave_top
  import mdio_slave_pkg::*;
(
  input  logic               mdc,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_addr,
  input  logic               mdio_in,
  output logic               mdio_out,
  output logic               mdio_oe
);
  logic               armed_q;
  logic [STRAP_W-1:0] strap_q;
  logic [RAW-1:0]     rd_addr, wr_addr;
  logic               rd_req, wr_stb;
  logic [DW-1:0]      rd_data, wr_data;
  logic               fr_match, fr_wr;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      strap_q <= '0;
    end else if (!armed_q) begin
      armed_q <= 1'b1;
      strap_q <= strap_addr;
    end
  end

  mdio_frame_fsm u_fsm (
    .clk        (mdc),
    .rst_n      (rst_n),
    .en         (armed_q),
    .line_in    (mdio_in),
    .strap      (strap_q),
    .rd_data    (rd_data),
    .rd_addr    (rd_addr),
    .rd_req     (rd_req),
    .wr_addr    (wr_addr),
    .wr_stb     (wr_stb),
    .wr_data    (wr_data),
    .drv_val    (mdio_out),
    .drv_en     (mdio_oe),
    .addr_match (fr_match),
    .frame_wr   (fr_wr)
  );

  mdio_regbank u_bank (
    .clk     (mdc),
    .rst_n   (rst_n),
    .en      (armed_q),
    .rd_addr (rd_addr),
    .rd_req  (rd_req),
    .rd_data (rd_data),
    .wr_addr (wr_addr),
    .wr_stb  (wr_stb),
    .wr_data (wr_data)
  );
endmodule

// File: rtl/mdio_slave_chk.sv
module mdio_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       armed,
  input logic       mdio_oe,
  input logic       mdio_out,
  input logic       match,
  input logic       frame_wr,
  input logic [3:0] strap_q
);
  AST_NO_DRIVE_UNARMED: assert property (@(posedge clk) disable iff (!rst_n) !armed |-> !mdio_oe); // R7
  AST_TA_ZERO: assert property (@(posedge clk) disable iff (!rst_n) $rose(mdio_oe) |-> !mdio_out); // R4
  AST_DRIVE_SPAN: assert property (@(posedge clk) disable iff (!rst_n) $fell(mdio_oe) |-> $past(mdio_oe, 17)); // R4
  AST_DRIVE_MATCH: assert property (@(posedge clk) disable iff (!rst_n) mdio_oe |-> match); // R3
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) frame_wr |-> !mdio_oe); // R5
  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (armed && $past(armed)) |-> $stable(strap_q)); // R6
endmodule

bind mdio_slave_top mdio_slave_chk u_chk (
  .clk      (mdc),
  .rst_n    (rst_n),
  .armed    (armed_q),
  .mdio_oe  (mdio_oe),
  .mdio_out (mdio_out),
  .match    (fr_match),
  .frame_wr (fr_wr),
  .strap_q  (strap_q)
);

// File: tb/sim_mdio_slave_top.sv
`timescale 1ns/1ps
module sim_mdio_slave_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] strap = 4'h5;
  logic       drv_en = 1'b0;
  logic       drv = 1'b1;
  logic       mdio_out, mdio_oe;
  wire        line = drv_en ? drv : (mdio_oe ? mdio_out : 1'b1);

  int total = 0;
  int bad = 0;

  logic [15:0] mdl [32];
  logic [15:0] mext [16];
  logic [15:0] mxaddr;
  logic [1:0]  mfn;
  logic [4:0]  mdev;
  logic [3:0]  my_addr;

  always #2.5 clk = ~clk;

  mdio_slave_top u0 (
    .mdc(clk), .rst_n(rst_n), .strap_addr(strap),
    .mdio_in(line), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(input logic [4:0] ra);
    if (ra == 5'd13) return {mfn, 9'd0, mdev};
    if (ra == 5'd14) return (mfn == 2'b00) ? mxaddr : mext[mxaddr[3:0]];
    return mdl[ra];
  endfunction

  task automatic model_write(input logic [4:0] ra, input logic [15:0] d);
    if (ra == 5'd13) begin
      mfn = d[15:14]; mdev = d[4:0];
    end else if (ra == 5'd14) begin
      if (mfn == 2'b00) mxaddr = d;
      else begin
        mext[mxaddr[3:0]] = d;
        if (mfn != 2'b01) mxaddr = mxaddr + 16'd1;
      end
    end else mdl[ra] = d;
  endtask

  task automatic model_read_side(input logic [4:0] ra);
    if (ra == 5'd14 && mfn == 2'b10) mxaddr = mxaddr + 16'd1;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    drv_en = 1'b1;
    drv = b;
  endtask

  task automatic send_head(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra);
    send_bit(1'b1); send_bit(1'b1);
    send_bit(1'b0); send_bit(1'b1);
    for (int i = 1; i >= 0; i--) send_bit(op[i]);
    for (int i = 4; i >= 0; i--) send_bit(pa[i]);
    for (int i = 4; i >= 0; i--) send_bit(ra[i]);
  endtask

  // Returns read data; proto_ok reports the turnaround and release pattern.
  task automatic rd_frame(input logic [4:0] pa, input logic [4:0] ra,
                          output logic [15:0] d, output logic proto_ok, output logic any_oe);
    send_head(2'b10, pa, ra);
    proto_ok = 1'b1; any_oe = 1'b0; d = '0;
    @(negedge clk); drv_en = 1'b0;
    if (mdio_oe) proto_ok = 1'b0;
    any_oe |= mdio_oe;
    @(negedge clk);
    if (!(mdio_oe && !mdio_out)) proto_ok = 1'b0;
    any_oe |= mdio_oe;
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk);
      if (!mdio_oe) proto_ok = 1'b0;
      any_oe |= mdio_oe;
      d[i] = line;
    end
    @(negedge clk);
    if (mdio_oe) proto_ok = 1'b0;
    any_oe |= mdio_oe;
    drv_en = 1'b1; drv = 1'b1;
  endtask

  task automatic wr_frame(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d,
                          output logic any_oe);
    any_oe = 1'b0;
    send_head(2'b01, pa, ra);
    send_bit(1'b1); any_oe |= mdio_oe;
    send_bit(1'b0); any_oe |= mdio_oe;
    for (int i = 15; i >= 0; i--) begin
      send_bit(d[i]);
      any_oe |= mdio_oe;
    end
    send_bit(1'b1); any_oe |= mdio_oe;
  endtask

  task automatic do_write(input logic [4:0] ra, input logic [15:0] d, input string req);
    logic oe;
    wr_frame({1'b0, my_addr}, ra, d, oe);
    check({req, " write never drives (R5)"}, oe, 1'b0);
    model_write(ra, d);
  endtask

  task automatic do_read(input logic [4:0] ra, input string req);
    logic [15:0] d;
    logic ok, oe;
    logic [15:0] e;
    e = exp_read(ra);
    rd_frame({1'b0, my_addr}, ra, d, ok, oe);
    check({req, " read turnaround (R4)"}, ok, 1'b1);
    check({req, " read data"}, d, e);
    model_read_side(ra);
  endtask

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic ok, oe;
    void'($urandom(32'h1d2c));
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    for (int i = 0; i < 16; i++) mext[i] = '0;
    mxaddr = '0; mfn = 2'b00; mdev = '0;
    my_addr = 4'h5;

    // R7: a 1 on the first edge after reset must not count as idle.
    drv_en = 1'b1; drv = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 reset oe low", mdio_oe, 1'b0);
    @(negedge clk); drv = 1'b1; rst_n = 1'b1;   // first posedge samples 1 (ignored)
    @(negedge clk); drv = 1'b0;                  // 0: no idle seen yet
    strap = 4'hA;                                // R6: changes after capture
    @(negedge clk); drv = 1'b1;
    for (int i = 1; i >= 0; i--) send_bit(2'b10 >> i);
    for (int i = 4; i >= 0; i--) send_bit(5'h05 >> i);
    for (int i = 4; i >= 0; i--) send_bit(5'h00 >> i);
    oe = 1'b0;
    repeat (20) begin
      @(negedge clk); drv_en = 1'b0; oe |= mdio_oe;
    end
    check("R7 first edge ignored, no drive", oe, 1'b0);
    drv_en = 1'b1; drv = 1'b1;
    repeat (3) @(negedge clk);

    // R8 reset values
    do_read(5'd3, "R8 reset value");
    do_read(5'd31, "R8 reset value top");
    // R6: captured strap 5 responds, new strap value A does not
    wr_frame(5'h0A, 5'd2, 16'hBEEF, oe);
    check("R6 later strap ignored no drive", oe, 1'b0);
    do_read(5'd2, "R6 later strap no write");
    // R3: MSB of address set
    rd_frame(5'h15, 5'd2, d, ok, oe);
    check("R3 msb set no drive", oe, 1'b0);
    wr_frame(5'h15, 5'd2, 16'h1234, oe);
    do_read(5'd2, "R3 msb set no write");
    // R5/R8 writes
    do_write(5'd0, 16'hA5C3, "R8");
    do_write(5'd31, 16'h8001, "R8");
    do_read(5'd0, "R8 r0");
    do_read(5'd31, "R8 r31");
    // R2 abort: opcode 11 then idle; a following read still works
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    oe = 1'b0;
    repeat (20) begin send_bit(1'b1); oe |= mdio_oe; end
    check("R2 opcode 11 no drive", oe, 1'b0);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
    repeat (20) begin send_bit(1'b1); oe |= mdio_oe; end
    check("R2 opcode 00 no drive", oe, 1'b0);
    do_read(5'd0, "R2 after abort");
    // R1: frame with long preamble
    repeat (10) send_bit(1'b1);
    do_read(5'd31, "R1 long idle");

    // R9 control register
    do_write(5'd13, 16'hFFFF, "R9");
    do_read(5'd13, "R9 reserved zero");
    // R10 address function
    do_write(5'd13, 16'h0003, "R10");
    do_write(5'd14, 16'h0012, "R10");
    do_read(5'd14, "R10 address readback");
    // R11 data no increment
    do_write(5'd13, 16'h4003, "R11");
    do_write(5'd14, 16'hCAFE, "R11");
    do_read(5'd14, "R11 data");
    do_read(5'd14, "R11 no increment");
    // R12 increment on read and write
    do_write(5'd13, 16'h8003, "R12");
    do_write(5'd14, 16'h1111, "R12");
    do_write(5'd14, 16'h2222, "R12");
    do_write(5'd13, 16'h0003, "R12");
    do_write(5'd14, 16'h0002, "R12");
    do_write(5'd13, 16'h8003, "R12");
    do_read(5'd14, "R12 read inc first");
    do_read(5'd14, "R12 read inc second");
    do_write(5'd13, 16'h0003, "R12");
    do_read(5'd14, "R12 address after reads");
    // R13 increment on write only
    do_write(5'd13, 16'hC003, "R13");
    do_read(5'd14, "R13 read no inc");
    do_read(5'd14, "R13 read no inc again");
    do_write(5'd14, 16'h7777, "R13");
    do_write(5'd13, 16'h0003, "R13");
    do_read(5'd14, "R13 address after write");

    // R8 random traffic on plain registers, mixed with foreign addresses (R3)
    for (int n = 0; n < 40; n++) begin
      logic [4:0] ra;
      logic [15:0] wd;
      ra = 5'($urandom_range(0, 31));
      if (ra == 5'd13 || ra == 5'd14) ra = 5'd7;
      wd = 16'($urandom);
      case ($urandom_range(0, 2))
        0: do_write(ra, wd, "R8 random");
        1: do_read(ra, "R8 random");
        default: begin
          wr_frame({1'b0, 4'($urandom_range(6, 15))}, ra, wd, oe);
          check("R3 foreign write no drive", oe, 1'b0);
        end
      endcase
    end
    for (int i = 0; i < 32; i++)
      if (i != 13 && i != 14) do_read(5'(i), "R8 final sweep");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule